// File: doc/BRIEF.md
# Mixed-Size Page Translation Lookup Array

This block is a small fully associative array of translation entries. Each entry holds a virtual page tag, a two-bit size level, a physical page number, seven permission bits and a page-fault marker. The level of an entry sets how much of the virtual page number it compares and how the physical page number is put together. An entry can therefore stand for a 4 KiB, 2 MiB or 1 GiB page. By default the virtual page number is 27 bits, split into three 9-bit segments, and the physical page number is 44 bits.

A page walker, which is outside this block, fills one way per cycle through the refill port. The caller chooses the way. The lookup port is combinational. It takes a virtual page number and an access kind, and in the same cycle it returns a per-way match vector, a merged hit flag, the composed physical page number, the stored permissions, the fault marker, and the marker routed to a load, store or fetch fault line. A flush input empties the whole array on the next clock edge.

Top module: `mlx_xlat_array`

## Requirements
- R1: After reset, no way is valid: `rd_hit` is 0 and `rd_hit_vec` is all zeros for any lookup.
- R2: An entry with level 2 (4 KiB) matches only when all 27 VPN bits are equal to its tag.
- R3: An entry with level 1 (2 MiB) compares VPN bits [26:9] only. The low segment, bits [8:0], has no effect on the match.
- R4: An entry with level 0 (1 GiB) compares VPN bits [26:18] only.
- R5: The output PPN depends on the level of the selected entry. For level 0 it is stored PPN bits [43:18] followed by request VPN bits [17:0]. For level 1 it is stored PPN bits [43:9] followed by VPN bits [8:0]. For level 2 it is the stored PPN unchanged.
- R6: An entry written with level 3 never matches.
- R7: `rd_hit_vec` has one bit per way, and bit w is set when way w is valid and matches. Every matching way is flagged, and `rd_hit` is the OR of all the bits.
- R8: When several ways match, PPN, permissions and fault marker all come from the lowest-indexed matching way.
- R9: A refill at a clock edge with `wr_en` high and `flush` low writes way `wr_way`. The new contents are visible from the next cycle, and the other ways keep their contents.
- R10: A flush empties every way at the next clock edge. Lookups in the cycle in which flush is raised still see the old contents. A refill in the same cycle as a flush is discarded.
- R11: A hit on an entry whose fault marker is set raises exactly one fault line, chosen by `rd_acc`: 00 gives load, 01 gives store, 10 gives fetch, and 11 gives none. Atomic accesses are passed with the same low two bits: a load-reserved access as 00, and a store-conditional or AMO access as 01. Without a hit on a marked entry, no fault line is raised.
- R12: `rd_perm` returns the seven stored bits unchanged. Bit 6 is dirty, 5 is accessed, 4 is global, 3 is user, 2 is execute, 1 is write and 0 is read.
- R13: On a miss, `rd_ppn`, `rd_perm` and `rd_pf` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset, clears all valid bits |
| flush | input | 1 | Empty the array at the next edge; takes priority over refill |
| wr_en | input | 1 | Refill strobe |
| wr_way | input | IDX_W | Way index to refill |
| wr_vpn | input | VPN_W | Virtual page tag to store |
| wr_level | input | 2 | Page size level: 0 = 1 GiB, 1 = 2 MiB, 2 = 4 KiB |
| wr_ppn | input | PPN_W | Physical page number to store |
| wr_perm | input | 7 | Permission bits, in the order given in R12 |
| wr_pf | input | 1 | Page-fault marker from the walker |
| rd_vpn | input | VPN_W | Lookup virtual page number |
| rd_acc | input | 2 | Access kind: 00 load, 01 store, 10 fetch |
| rd_hit | output | 1 | At least one way matches |
| rd_hit_vec | output | WAYS | Per-way match vector |
| rd_ppn | output | PPN_W | Composed physical page number |
| rd_perm | output | 7 | Permissions of the selected way |
| rd_pf | output | 1 | Fault marker of the selected way |
| rd_flt_load | output | 1 | Load page fault |
| rd_flt_store | output | 1 | Store page fault |
| rd_flt_fetch | output | 1 | Fetch page fault |

## Verification
The assertions check, on every cycle, the properties that hold regardless of the stored contents. These are: outputs are zero on a miss, the array is empty after a flush, a refill is visible in the next cycle, and at most one fault line is raised, only ever from a hit on a marked entry.

The bench scenarios are needed for the rest:
- the level-dependent match depth, found by sweeping all eight combinations of mismatched segments for each level;
- the way the PPN is assembled;
- the lowest-index winner when several ways overlap;
- isolation of the other ways during a refill;
- the refill that is lost when it collides with a flush.

// File: rtl/mlx_pkg.sv
package mlx_pkg;

   // Permission bits as stored in a translation entry, most significant first.
   typedef struct packed {
      logic dirty;
      logic accessed;
      logic global_map;
      logic user;
      logic exec;
      logic write;
      logic read;
   } mlx_perm_t;

   localparam int PERM_W = $bits(mlx_perm_t);
   localparam int LVL_W  = 2;

   // Kind of access, decoded from the low two command bits.
   typedef enum logic [1:0] {
      ACC_LOAD  = 2'b00,
      ACC_STORE = 2'b01,
      ACC_FETCH = 2'b10,
      ACC_RSVD  = 2'b11
   } acc_kind_e;

endpackage

// File: rtl/mlx_way.sv
module mlx_way
   import mlx_pkg::*;
#(
   parameter int SEG_W = 9,
   parameter int SEGS  = 3,
   parameter int PPN_W = 44,
   localparam int VPN_W = SEG_W * SEGS
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush,
   input  logic             wr_sel,
   input  logic [VPN_W-1:0] wr_vpn,
   input  logic [LVL_W-1:0] wr_level,
   input  logic [PPN_W-1:0] wr_ppn,
   input  mlx_perm_t        wr_perm,
   input  logic             wr_pf,
   input  logic [VPN_W-1:0] rd_vpn,
   output logic             match,
   output logic [LVL_W-1:0] ent_level,
   output logic [PPN_W-1:0] ent_ppn,
   output mlx_perm_t        ent_perm,
   output logic             ent_pf
);

   logic             vld_q;
   logic [VPN_W-1:0] tag_q;
   logic [LVL_W-1:0] lvl_q;
   logic [PPN_W-1:0] ppn_q;
   mlx_perm_t        perm_q;
   logic             pf_q;

   // Valid bit: a flush beats a refill in the same cycle.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      vld_q <= 1'b0;
      else if (flush)  vld_q <= 1'b0;
      else if (wr_sel) vld_q <= 1'b1;
   end

   always_ff @(posedge clk) begin
      if (wr_sel && !flush) begin
         tag_q  <= wr_vpn;
         lvl_q  <= wr_level;
         ppn_q  <= wr_ppn;
         perm_q <= wr_perm;
         pf_q   <= wr_pf;
      end
   end

   // Level l compares the top l+1 segments, i.e. segment s counts when s + l >= SEGS-1.
   logic [SEGS-1:0] seg_eq;
   logic [SEGS-1:0] seg_need;
   for (genvar s = 0; s < SEGS; s++) begin : g_seg
      assign seg_eq[s]   = (tag_q[s*SEG_W +: SEG_W] == rd_vpn[s*SEG_W +: SEG_W]);
      assign seg_need[s] = (int'(lvl_q) + s) >= (SEGS - 1);
   end

   logic lvl_ok;
   assign lvl_ok    = int'(lvl_q) < SEGS;
   assign match     = vld_q && lvl_ok && (&(seg_eq | ~seg_need));
   assign ent_level = lvl_q;
   assign ent_ppn   = ppn_q;
   assign ent_perm  = perm_q;
   assign ent_pf    = pf_q;

endmodule

// File: rtl/mlx_ppn_compose.sv
module mlx_ppn_compose
   import mlx_pkg::*;
#(
   parameter int SEG_W = 9,
   parameter int SEGS  = 3,
   parameter int PPN_W = 44,
   localparam int VPN_W = SEG_W * SEGS
) (
   input  logic [LVL_W-1:0] level,
   input  logic [PPN_W-1:0] ppn,
   input  logic [VPN_W-1:0] vpn,
   output logic [PPN_W-1:0] phys
);

   // A large page keeps its low (SEGS-1-level) segments from the request address.
   always_comb begin
      phys = ppn;
      for (int s = 0; s < SEGS - 1; s++) begin
         if (s + int'(level) < SEGS - 1) begin
            phys[s*SEG_W +: SEG_W] = vpn[s*SEG_W +: SEG_W];
         end
      end
   end

endmodule

// File: rtl/mlx_fault_route.sv
module mlx_fault_route
   import mlx_pkg::*;
(
   input  logic       hit,
   input  logic       pf,
   input  logic [1:0] acc,
   output logic       flt_load,
   output logic       flt_store,
   output logic       flt_fetch
);

   acc_kind_e kind;
   logic      raise;

   assign kind  = acc_kind_e'(acc);
   assign raise = hit && pf;

   always_comb begin
      flt_load  = 1'b0;
      flt_store = 1'b0;
      flt_fetch = 1'b0;
      case (kind)
         ACC_LOAD:  flt_load  = raise;
         ACC_STORE: flt_store = raise;
         ACC_FETCH: flt_fetch = raise;
         default:   ;
      endcase
   end

endmodule

// File: rtl/mlx_xlat_array.sv
module mlx_xlat_array
   import mlx_pkg::*;
#(
   parameter int SEG_W = 9,
   parameter int SEGS  = 3,
   parameter int PPN_W = 44,
   parameter int WAYS  = 16,
   localparam int VPN_W = SEG_W * SEGS,
   localparam int IDX_W = $clog2(WAYS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_way,
   input  logic [VPN_W-1:0]  wr_vpn,
   input  logic [1:0]        wr_level,
   input  logic [PPN_W-1:0]  wr_ppn,
   input  logic [6:0]        wr_perm,
   input  logic              wr_pf,
   input  logic [VPN_W-1:0]  rd_vpn,
   input  logic [1:0]        rd_acc,
   output logic              rd_hit,
   output logic [WAYS-1:0]   rd_hit_vec,
   output logic [PPN_W-1:0]  rd_ppn,
   output logic [6:0]        rd_perm,
   output logic              rd_pf,
   output logic              rd_flt_load,
   output logic              rd_flt_store,
   output logic              rd_flt_fetch
);

   if (SEGS < 2 || SEGS > 4) begin : g_bad_segs
      $error("mlx_xlat_array: SEGS must be 2..4 for a 2-bit level");
   end
   if (WAYS < 2) begin : g_bad_ways
      $error("mlx_xlat_array: WAYS must be at least 2");
   end
   if (PPN_W < SEG_W * (SEGS - 1)) begin : g_bad_ppn
      $error("mlx_xlat_array: PPN_W too narrow for the largest page");
   end

   logic [LVL_W-1:0] lvl_w  [WAYS];
   logic [PPN_W-1:0] ppn_w  [WAYS];
   mlx_perm_t        perm_w [WAYS];
   logic             pf_w   [WAYS];
   logic [WAYS-1:0]  match_w;

   for (genvar w = 0; w < WAYS; w++) begin : g_way
      logic sel;
      assign sel = wr_en && (wr_way == IDX_W'(w));
      mlx_way #(.SEG_W(SEG_W), .SEGS(SEGS), .PPN_W(PPN_W)) u_way (
         .clk       (clk),
         .rst_n     (rst_n),
         .flush     (flush),
         .wr_sel    (sel),
         .wr_vpn    (wr_vpn),
         .wr_level  (wr_level),
         .wr_ppn    (wr_ppn),
         .wr_perm   (mlx_perm_t'(wr_perm)),
         .wr_pf     (wr_pf),
         .rd_vpn    (rd_vpn),
         .match     (match_w[w]),
         .ent_level (lvl_w[w]),
         .ent_ppn   (ppn_w[w]),
         .ent_perm  (perm_w[w]),
         .ent_pf    (pf_w[w])
      );
   end

   // Lowest-index winner: scan downward so the last assignment is the smallest index.
   logic [LVL_W-1:0] sel_lvl;
   logic [PPN_W-1:0] sel_ppn;
   mlx_perm_t        sel_perm;
   logic             sel_pf;
   logic             any_hit;

   always_comb begin
      sel_lvl  = '0;
      sel_ppn  = '0;
      sel_perm = '0;
      sel_pf   = 1'b0;
      any_hit  = 1'b0;
      for (int w = WAYS - 1; w >= 0; w--) begin
         if (match_w[w]) begin
            sel_lvl  = lvl_w[w];
            sel_ppn  = ppn_w[w];
            sel_perm = perm_w[w];
            sel_pf   = pf_w[w];
            any_hit  = 1'b1;
         end
      end
   end

   logic [PPN_W-1:0] phys;
   mlx_ppn_compose #(.SEG_W(SEG_W), .SEGS(SEGS), .PPN_W(PPN_W)) u_compose (
      .level (sel_lvl),
      .ppn   (sel_ppn),
      .vpn   (rd_vpn),
      .phys  (phys)
   );

   mlx_fault_route u_route (
      .hit       (any_hit),
      .pf        (sel_pf),
      .acc       (rd_acc),
      .flt_load  (rd_flt_load),
      .flt_store (rd_flt_store),
      .flt_fetch (rd_flt_fetch)
   );

   assign rd_hit     = any_hit;
   assign rd_hit_vec = match_w;
   assign rd_ppn     = any_hit ? phys : '0;
   assign rd_perm    = sel_perm;
   assign rd_pf      = sel_pf;

endmodule

// File: rtl/mlx_xlat_array_chk.sv
module mlx_xlat_array_chk #(
   parameter int SEG_W = 9,
   parameter int SEGS  = 3,
   parameter int PPN_W = 44,
   parameter int WAYS  = 16,
   localparam int VPN_W = SEG_W * SEGS,
   localparam int IDX_W = $clog2(WAYS)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              flush,
   input logic              wr_en,
   input logic [IDX_W-1:0]  wr_way,
   input logic [VPN_W-1:0]  wr_vpn,
   input logic [1:0]        wr_level,
   input logic [VPN_W-1:0]  rd_vpn,
   input logic [1:0]        rd_acc,
   input logic              rd_hit,
   input logic [WAYS-1:0]   rd_hit_vec,
   input logic [PPN_W-1:0]  rd_ppn,
   input logic [6:0]        rd_perm,
   input logic              rd_pf,
   input logic              rd_flt_load,
   input logic              rd_flt_store,
   input logic              rd_flt_fetch
);

   assert_reset_empty_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (rd_hit_vec == '0));

   assert_miss_zero_R13: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_hit |-> (rd_ppn == '0 && rd_perm == '0 && !rd_pf));

   assert_flush_empties_R10: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (rd_hit_vec == '0 && !rd_hit));

   assert_refill_visible_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(wr_en && !flush) && (int'($past(wr_level)) < SEGS)
       && rd_vpn == $past(wr_vpn)) |-> rd_hit_vec[$past(wr_way)]);

   assert_fault_onehot_R11: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({rd_flt_load, rd_flt_store, rd_flt_fetch}));

   assert_fault_cause_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_flt_load || rd_flt_store || rd_flt_fetch) |-> (rd_hit && rd_pf));

   assert_fault_raised_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_hit && rd_pf && rd_acc != 2'b11) |->
      ($countones({rd_flt_load, rd_flt_store, rd_flt_fetch}) == 1));

endmodule

bind mlx_xlat_array mlx_xlat_array_chk #(
   .SEG_W(SEG_W), .SEGS(SEGS), .PPN_W(PPN_W), .WAYS(WAYS)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .flush        (flush),
   .wr_en        (wr_en),
   .wr_way       (wr_way),
   .wr_vpn       (wr_vpn),
   .wr_level     (wr_level),
   .rd_vpn       (rd_vpn),
   .rd_acc       (rd_acc),
   .rd_hit       (rd_hit),
   .rd_hit_vec   (rd_hit_vec),
   .rd_ppn       (rd_ppn),
   .rd_perm      (rd_perm),
   .rd_pf        (rd_pf),
   .rd_flt_load  (rd_flt_load),
   .rd_flt_store (rd_flt_store),
   .rd_flt_fetch (rd_flt_fetch)
);

// File: tb/mlx_xlat_array_tb.sv
`timescale 1ns/1ps
module mlx_xlat_array_tb_top;

   localparam int SEG_W = 9;
   localparam int SEGS  = 3;
   localparam int PPN_W = 44;
   localparam int WAYS  = 4;
   localparam int VPN_W = SEG_W * SEGS;
   localparam int IDX_W = $clog2(WAYS);

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              flush = 1'b0;
   logic              wr_en = 1'b0;
   logic [IDX_W-1:0]  wr_way = '0;
   logic [VPN_W-1:0]  wr_vpn = '0;
   logic [1:0]        wr_level = '0;
   logic [PPN_W-1:0]  wr_ppn = '0;
   logic [6:0]        wr_perm = '0;
   logic              wr_pf = 1'b0;
   logic [VPN_W-1:0]  rd_vpn = '0;
   logic [1:0]        rd_acc = '0;
   logic              rd_hit;
   logic [WAYS-1:0]   rd_hit_vec;
   logic [PPN_W-1:0]  rd_ppn;
   logic [6:0]        rd_perm;
   logic              rd_pf;
   logic              rd_flt_load, rd_flt_store, rd_flt_fetch;

   always #4 clk = ~clk;

   mlx_xlat_array #(.SEG_W(SEG_W), .SEGS(SEGS), .PPN_W(PPN_W), .WAYS(WAYS)) dut_i (
      .clk(clk), .rst_n(rst_n), .flush(flush), .wr_en(wr_en), .wr_way(wr_way),
      .wr_vpn(wr_vpn), .wr_level(wr_level), .wr_ppn(wr_ppn), .wr_perm(wr_perm),
      .wr_pf(wr_pf), .rd_vpn(rd_vpn), .rd_acc(rd_acc), .rd_hit(rd_hit),
      .rd_hit_vec(rd_hit_vec), .rd_ppn(rd_ppn), .rd_perm(rd_perm), .rd_pf(rd_pf),
      .rd_flt_load(rd_flt_load), .rd_flt_store(rd_flt_store), .rd_flt_fetch(rd_flt_fetch)
   );

   int n_chk = 0;
   int n_err = 0;
   logic done = 1'b0;

   // Reference model of the array, written from the requirements.
   logic             m_v    [WAYS];
   logic [VPN_W-1:0] m_vpn  [WAYS];
   logic [1:0]       m_lvl  [WAYS];
   logic [PPN_W-1:0] m_ppn  [WAYS];
   logic [6:0]       m_perm [WAYS];
   logic             m_pf   [WAYS];

   function automatic logic m_hits(int w, logic [VPN_W-1:0] v);
      case (m_lvl[w])
         2'd0:    return v[26:18] == m_vpn[w][26:18];
         2'd1:    return v[26:9]  == m_vpn[w][26:9];
         2'd2:    return v == m_vpn[w];
         default: return 1'b0;
      endcase
   endfunction

   function automatic logic [PPN_W-1:0] m_compose(int w, logic [VPN_W-1:0] v);
      case (m_lvl[w])
         2'd0:    return {m_ppn[w][43:18], v[17:0]};
         2'd1:    return {m_ppn[w][43:9], v[8:0]};
         default: return m_ppn[w];
      endcase
   endfunction

   task automatic m_clear();
      for (int w = 0; w < WAYS; w++) m_v[w] = 1'b0;
   endtask

   task automatic probe_now(input logic [VPN_W-1:0] v, input logic [1:0] acc, input string req);
      logic            e_hit;
      logic [WAYS-1:0] e_vec;
      logic [PPN_W-1:0] e_ppn;
      logic [6:0]      e_perm;
      logic            e_pf;
      logic [2:0]      e_flt;
      logic [2:0]      a_flt;
      e_hit = 1'b0; e_vec = '0; e_ppn = '0; e_perm = '0; e_pf = 1'b0;
      for (int w = WAYS - 1; w >= 0; w--) begin
         if (m_v[w] && m_hits(w, v)) begin
            e_vec[w] = 1'b1;
            e_hit    = 1'b1;
            e_ppn    = m_compose(w, v);
            e_perm   = m_perm[w];
            e_pf     = m_pf[w];
         end
      end
      e_flt = 3'b000;
      if (e_hit && e_pf) begin
         case (acc)
            2'b00:   e_flt = 3'b001;
            2'b01:   e_flt = 3'b010;
            2'b10:   e_flt = 3'b100;
            default: e_flt = 3'b000;
         endcase
      end
      rd_vpn = v;
      rd_acc = acc;
      #1;
      a_flt = {rd_flt_fetch, rd_flt_store, rd_flt_load};
      n_chk++;
      if ({rd_hit, rd_hit_vec, rd_ppn, rd_perm, rd_pf, a_flt} !==
          {e_hit, e_vec, e_ppn, e_perm, e_pf, e_flt}) begin
         n_err++;
         $display("FAIL %s vpn=%h acc=%b got hit=%b vec=%b ppn=%h perm=%b pf=%b flt=%b exp hit=%b vec=%b ppn=%h perm=%b pf=%b flt=%b",
                  req, v, acc, rd_hit, rd_hit_vec, rd_ppn, rd_perm, rd_pf, a_flt,
                  e_hit, e_vec, e_ppn, e_perm, e_pf, e_flt);
      end
   endtask

   task automatic probe(input logic [VPN_W-1:0] v, input logic [1:0] acc, input string req);
      @(negedge clk);
      probe_now(v, acc, req);
   endtask

   task automatic refill(input int w, input logic [VPN_W-1:0] v, input logic [1:0] lvl,
                         input logic [PPN_W-1:0] p, input logic [6:0] pm, input logic pf);
      @(negedge clk);
      wr_en = 1'b1; wr_way = IDX_W'(w); wr_vpn = v; wr_level = lvl;
      wr_ppn = p; wr_perm = pm; wr_pf = pf;
      @(negedge clk);
      wr_en = 1'b0;
      m_v[w] = 1'b1; m_vpn[w] = v; m_lvl[w] = lvl; m_ppn[w] = p; m_perm[w] = pm; m_pf[w] = pf;
   endtask

   task automatic do_flush();
      @(negedge clk);
      flush = 1'b1;
      @(negedge clk);
      flush = 1'b0;
      m_clear();
   endtask

   localparam logic [VPN_W-1:0] BASE = 27'h5A5_A5A5;
   localparam logic [PPN_W-1:0] PBIG = 44'hABC_DEF0_1234;

   initial begin
      m_clear();
      for (int w = 0; w < WAYS; w++) begin
         m_vpn[w] = '0; m_lvl[w] = '0; m_ppn[w] = '0; m_perm[w] = '0; m_pf[w] = 1'b0;
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 / R13: empty after reset, zero outputs on a miss
      probe(BASE, 2'b00, "R1");
      probe('0, 2'b01, "R13");

      // R2..R6: each level against all eight mismatched-segment patterns
      for (int lvl = 0; lvl < 4; lvl++) begin
         string tag;
         tag = (lvl == 0) ? "R4/R5" : (lvl == 1) ? "R3/R5" : (lvl == 2) ? "R2/R5" : "R6";
         do_flush();
         refill(1, BASE, 2'(lvl), PBIG, 7'h55, 1'b0);
         for (int msk = 0; msk < 8; msk++) begin
            logic [VPN_W-1:0] v;
            v = BASE;
            for (int s = 0; s < 3; s++) if (msk[s]) v[s*9+3] = ~v[s*9+3];
            probe(v, 2'b00, tag);
         end
      end

      // R7 / R8: overlapping entries of different sizes
      do_flush();
      refill(3, BASE, 2'd2, 44'h111_1111_1111, 7'h03, 1'b0);
      refill(1, {BASE[26:18], 18'h0_0F0F}, 2'd0, 44'h222_2222_2222, 7'h05, 1'b1);
      refill(2, {BASE[26:9], 9'h1FF}, 2'd1, 44'h333_3333_3333, 7'h11, 1'b0);
      probe(BASE, 2'b00, "R7/R8");
      probe({BASE[26:9], 9'h000}, 2'b01, "R7/R8");
      probe({BASE[26:18], 18'h3_0000}, 2'b10, "R7/R8");
      refill(0, BASE, 2'd2, 44'h444_4444_4444, 7'h7F, 1'b0);
      probe(BASE, 2'b00, "R8");

      // R9: rewriting one way leaves the others intact
      refill(1, 27'h012_3456, 2'd2, 44'h555_5555_5555, 7'h0A, 1'b0);
      probe(BASE, 2'b00, "R9");
      probe(27'h012_3456, 2'b00, "R9");
      probe({BASE[26:9], 9'h001}, 2'b00, "R9");

      // R12: every permission pattern returned unchanged
      do_flush();
      for (int pm = 0; pm < 128; pm++) begin
         refill(2, BASE ^ 27'(pm), 2'd2, 44'(pm) << 5, 7'(pm), 1'b0);
         probe(BASE ^ 27'(pm), 2'b00, "R12");
      end

      // R11: fault routing for marked and unmarked entries
      do_flush();
      refill(0, BASE, 2'd2, PBIG, 7'h0F, 1'b1);
      refill(1, 27'h7FF_FFFF, 2'd2, PBIG, 7'h0F, 1'b0);
      for (int a = 0; a < 4; a++) begin
         probe(BASE, 2'(a), "R11");
         probe(27'h7FF_FFFF, 2'(a), "R11");
         probe(27'h000_0001, 2'(a), "R11");
      end

      // R10: flush timing and flush/refill collision
      refill(2, 27'h246_8ACE, 2'd1, PBIG, 7'h01, 1'b0);
      @(negedge clk);
      flush = 1'b1;
      probe_now(BASE, 2'b00, "R10");
      @(negedge clk);
      flush = 1'b0;
      m_clear();
      probe_now(BASE, 2'b00, "R10");
      probe(27'h246_8ACE, 2'b00, "R10");
      @(negedge clk);
      flush = 1'b1;
      wr_en = 1'b1; wr_way = 2'd3; wr_vpn = BASE; wr_level = 2'd2; wr_ppn = PBIG;
      wr_perm = 7'h7F; wr_pf = 1'b0;
      @(negedge clk);
      flush = 1'b0;
      wr_en = 1'b0;
      probe_now(BASE, 2'b00, "R10");

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog expired, requirement all, got running exp finished");
         $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
         $finish;
      end
   end

endmodule